// File: doc/BRIEF.md
# Third-order sinc interpolation filter

This block raises the rate of 16-bit two's complement playback samples from the frame rate to the modulator rate. A host writes words into a single holding register whenever it likes. At each input-rate tick the filter takes whatever word the register holds. If nothing new has arrived since the previous tick, the old word is used again. The filter is a third-order cascaded integrator-comb interpolator: three comb stages run at the input rate, the stream is zero-stuffed by N, and three integrators run at the high rate. The gain of N² is removed with an arithmetic right shift, and the result is clipped to 16 bits.

The high-rate enable `hi_en` paces all filter activity. Every N enables form one input-rate tick, where N = 32 · 2^`rate_sel`. The input side uses a valid/ready handshake. `in_ready` is always high: a newer word simply replaces the held one, so the host is never held off. The output side has no ready. One word leaves for every high-rate enable, and the consumer has to take it because the modulator rate cannot stall. A bypass control turns the block into a zero-order hold with minimal delay. Changing the rate, or leaving bypass, restarts the filter from empty state.

Top module: `sinc3_interp`

## Requirements
- R1: After reset, `out_data` is 0 and `out_valid` is low.
- R2: `out_valid` is high for exactly the cycle after each cycle with `hi_en` high. `out_data` changes only in that cycle.
- R3: `in_ready` is always high. A cycle with `in_valid` high loads `in_data` into the held word. A tick uses the held word as it stood before that cycle's clock edge. With no new write, the previous word is used again.
- R4: Outside bypass, let high-rate enable k (counted from 0 after the last clear) produce output y_k. Then y_k = floor(S_k / N²) clipped to [-32768, 32767]. Here S_k = Σ_j x_j·h[k−3−jN], x_j is the word taken at enable jN, and h is the length-N all-ones box convolved with itself three times (h[0]=1).
- R5: With a constant held word, the output settles to exactly that word, including 0x7FFF (positive full scale) and 0x8000 (negative full scale), for each `rate_sel` code 0 to 3.
- R6: While `bypass` is high, each enable sends the held word (before that edge) straight to `out_data`.
- R7: A change of `rate_sel`, any cycle with `bypass` high, and the cycle after `bypass` falls all clear the filter state and the phase count. An enable in such a cycle, outside bypass, outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_en | input | 1 | High-rate enable, one pulse per output sample |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input ready, always high |
| in_data | input | 16 | Input word, two's complement |
| rate_sel | input | 2 | Rate code, N = 32 · 2^code |
| bypass | input | 1 | Zero-order hold without filtering |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output word, two's complement |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a smallest N of 32 and a 2-bit rate code. All four interpolation factors, up to N = 256, are therefore reachable. At N = 256 with full-scale inputs, the last integrator swings through nearly all of its 32 bits, so any lost width or wrong shift shows up. A gapped enable pattern is used, so ticks, writes on tick cycles, rate changes and bypass exits all fall on varied phases.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int ORDER = 3;

  // right shift that removes the N^2 gain for a given rate code
  function automatic int gain_shift(input int log2_nmin, input int code);
    return 2 * (log2_nmin + code);
  endfunction
endpackage

// File: rtl/sinc3_rate_ctrl.sv
module sinc3_rate_ctrl #(
  parameter int LOG2_NMIN = 5,
  parameter int RSEL_W    = 2,
  parameter int PH_W      = LOG2_NMIN + (2 ** RSEL_W) - 1,
  parameter int SH_W      = $clog2(2 * PH_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_en,
  input  logic [RSEL_W-1:0] rate_sel,
  input  logic              bypass,
  output logic              clr,
  output logic              step,
  output logic              tick,
  output logic [SH_W-1:0]   shamt
);
  logic [RSEL_W-1:0] rate_q;
  logic              byp_q;
  logic [PH_W-1:0]   ph, ph_mask;

  always_comb begin
    ph_mask = PH_W'((1 << (LOG2_NMIN + int'(rate_sel))) - 1);
    clr     = bypass | byp_q | (rate_sel != rate_q);
    step    = hi_en & ~clr;
    tick    = step & (ph == '0);
    shamt   = SH_W'(sinc3_pkg::gain_shift(LOG2_NMIN, int'(rate_sel)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= '0;
      byp_q  <= 1'b0;
      ph     <= '0;
    end else begin
      rate_q <= rate_sel;
      byp_q  <= bypass;
      if (clr)       ph <= '0;
      else if (step) ph <= (ph + 1'b1) & ph_mask;
    end
  end
endmodule

// File: rtl/sinc3_comb_stage.sv
module sinc3_comb_stage #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] y
);
  logic signed [W-1:0] dly;

  assign y = x - dly;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) dly <= '0;
    else if (en)       dly <= x;
  end
endmodule

// File: rtl/sinc3_integ_stage.sv
module sinc3_integ_stage #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic signed [W-1:0] u,
  output logic signed [W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (en)       acc <= acc + u;
  end
endmodule

// File: rtl/sinc3_interp.sv
module sinc3_interp #(
  parameter int DW        = 16,
  parameter int LOG2_NMIN = 5,
  parameter int RSEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic [RSEL_W-1:0] rate_sel,
  input  logic              bypass,
  output logic              out_valid,
  output logic [DW-1:0]     out_data
);
  localparam int ORDER = sinc3_pkg::ORDER;
  localparam int PH_W  = LOG2_NMIN + (2 ** RSEL_W) - 1;
  localparam int ACC_W = DW + 2 * PH_W;
  localparam int SH_W  = $clog2(2 * PH_W + 1);
  localparam logic signed [ACC_W-1:0] POS_FS = ACC_W'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_FS = -POS_FS - 1;

  logic [DW-1:0]       held;
  logic                clr, step, tick;
  logic [SH_W-1:0]     shamt;
  logic signed [ACC_W-1:0] cmb [0:ORDER];
  logic signed [ACC_W-1:0] ig  [0:ORDER];
  logic signed [ACC_W-1:0] scaled;
  logic [DW-1:0]       clipped;

  assign in_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)                    held <= '0;
    else if (in_valid && in_ready) held <= in_data;
  end

  sinc3_rate_ctrl #(.LOG2_NMIN(LOG2_NMIN), .RSEL_W(RSEL_W), .PH_W(PH_W), .SH_W(SH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hi_en(hi_en), .rate_sel(rate_sel), .bypass(bypass),
    .clr(clr), .step(step), .tick(tick), .shamt(shamt)
  );

  assign cmb[0] = {{(ACC_W-DW){held[DW-1]}}, held};
  assign ig[0]  = tick ? cmb[ORDER] : '0;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    sinc3_comb_stage #(.W(ACC_W)) u_comb (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(tick), .x(cmb[g]), .y(cmb[g+1])
    );
    sinc3_integ_stage #(.W(ACC_W)) u_integ (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(step), .u(ig[g]), .acc(ig[g+1])
    );
  end

  always_comb begin
    scaled = ig[ORDER] >>> shamt;
    if (scaled > POS_FS)      clipped = POS_FS[DW-1:0];
    else if (scaled < NEG_FS) clipped = NEG_FS[DW-1:0];
    else                      clipped = scaled[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= hi_en;
      if (hi_en) begin
        if (bypass)   out_data <= held;
        else if (clr) out_data <= '0;
        else          out_data <= clipped;
      end
    end
  end
endmodule

// File: rtl/sinc3_interp_chk.sv
module sinc3_interp_chk #(
  parameter int DW     = 16,
  parameter int RSEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hi_en,
  input logic              in_valid,
  input logic [DW-1:0]     in_data,
  input logic [RSEL_W-1:0] rate_sel,
  input logic              bypass,
  input logic              out_valid,
  input logic [DW-1:0]     out_data
);
  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_en |=> out_valid);
  // R2
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en |=> !out_valid);
  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en |=> $stable(out_data));
  // R6
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bypass) ##1 (hi_en && bypass && !in_valid) |=> out_data == $past(in_data, 2));
  // R7
  rate_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && hi_en && rate_sel != $past(rate_sel)) |=> out_data == '0);
endmodule

bind sinc3_interp sinc3_interp_chk #(.DW(DW), .RSEL_W(RSEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hi_en(hi_en), .in_valid(in_valid), .in_data(in_data),
  .rate_sel(rate_sel), .bypass(bypass), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_sinc3_interp.sv
module tb_sinc3_interp;
  localparam int CLK_PERIOD = 10;
  localparam int HMAX = 768;

  logic clk = 1'b0, rst_n = 1'b0, hi_en = 1'b0, in_valid = 1'b0, bypass = 1'b0;
  logic in_ready, out_valid;
  logic [15:0] in_data = '0, out_data;
  logic [1:0] rate_sel = '0;

  int n_vec = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int h [0:HMAX-1];
  int h_n = 0;
  int xs[$];
  int k_ev = 0;
  logic [15:0] held_m = '0, exp_data = '0;
  logic exp_valid = 1'b0, byp_prev = 1'b0, checking = 1'b0;
  logic [1:0] rate_prev = '0;

  sinc3_interp dut (
    .clk(clk), .rst_n(rst_n), .hi_en(hi_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rate_sel(rate_sel), .bypass(bypass), .out_valid(out_valid),
    .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void build_h(input int n);
    int b [0:2*HMAX];
    for (int i = 0; i < 2*n - 1; i++) begin
      b[i] = 0;
      for (int m = 0; m < n; m++) if (i - m >= 0 && i - m < n) b[i]++;
    end
    for (int i = 0; i < 3*n - 2; i++) begin
      h[i] = 0;
      for (int m = 0; m < n; m++) if (i - m >= 0 && i - m < 2*n - 1) h[i] += b[i-m];
    end
    h_n = n;
  endfunction

  function automatic logic [15:0] clip16(input longint v);
    if (v > 32767)  return 16'h7FFF;
    if (v < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      xs.delete(); k_ev = 0; held_m = '0; exp_data = '0; exp_valid = 1'b0;
      rate_prev = '0; byp_prev = 1'b0;
    end else begin
      automatic int n = 32 << rate_sel;
      automatic logic clr = bypass || byp_prev || (rate_sel != rate_prev);
      automatic longint s = 0;
      if (h_n != n) build_h(n);
      exp_valid = hi_en;
      if (hi_en) begin
        if (bypass) exp_data = held_m;
        else if (clr) exp_data = '0;
        else begin
          if (k_ev % n == 0) xs.push_back(int'($signed(held_m)));
          foreach (xs[j]) begin
            automatic int idx = k_ev - 3 - j*n;
            if (idx >= 0 && idx <= 3*n - 3) s += longint'(xs[j]) * h[idx];
          end
          exp_data = clip16(s >>> (2 * (5 + int'(rate_sel))));
          k_ev++;
        end
      end
      if (clr) begin xs.delete(); k_ev = 0; end
      if (in_valid) held_m = in_data;
      rate_prev = rate_sel;
      byp_prev = bypass;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      n_vec++;
      if (out_data !== exp_data || out_valid !== exp_valid || in_ready !== 1'b1) begin
        n_bad++;
        $display("FAIL %s: out_data=%h out_valid=%b in_ready=%b, expected %h %b 1",
                 cur_req, out_data, out_valid, in_ready, exp_data, exp_valid);
      end
    end
  end

  task automatic run(input int n, input int wr_every, input logic rnd, input logic [15:0] val);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi_en = (i % 3) != 2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid = (wr_every > 0) && (i % wr_every == 0);
      in_data = rnd ? lfsr : val;
    end
  endtask

  task automatic ctl(input logic [1:0] r, input logic b);
    @(negedge clk);
    hi_en = 1'b0; in_valid = 1'b0; rate_sel = r; bypass = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_vec++;
    if (out_data !== 16'h0 || out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: out_data=%h out_valid=%b, expected 0000 0", out_data, out_valid);
    end
    rst_n = 1'b1;
    checking = 1'b1;
    cur_req = "R5/R4/R2 rate0 positive full scale";
    run(250, 1000, 1'b0, 16'h7FFF);
    cur_req = "R3/R4 rate0 sparse and tick-aligned writes";
    run(700, 7, 1'b1, 16'h0);
    run(400, 45, 1'b1, 16'h0);
    cur_req = "R3 reuse without writes";
    run(300, 0, 1'b0, 16'h0);
    ctl(2'd1, 1'b0);
    cur_req = "R7/R5 rate1 negative full scale";
    run(1000, 1000, 1'b0, 16'h8000);
    ctl(2'd2, 1'b0);
    cur_req = "R4 rate2 varied words";
    run(1600, 200, 1'b1, 16'h0);
    ctl(2'd3, 1'b0);
    cur_req = "R5 rate3 full scale";
    run(1200, 2000, 1'b0, 16'h7FFF);
    run(1300, 2000, 1'b0, 16'h8000);
    ctl(2'd3, 1'b1);
    cur_req = "R6 bypass hold";
    run(120, 4, 1'b1, 16'h0);
    ctl(2'd0, 1'b0);
    cur_req = "R7 leaving bypass";
    run(400, 50, 1'b1, 16'h0);
    checking = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 200000);
    n_bad++;
    $display("FAIL watchdog: %0d cycles, expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule